// File: doc/BRIEF.md
# Frame-Safe Update Window Guard

This block decides when a burst of display register writes may begin so that the whole burst lands inside one frame. A requester raises a start pulse. The block then turns a fixed time budget, given in microseconds, into a number of scanlines, using the pixel clock in kHz and the horizontal total. From that it forms a guard band that ends one line before vertical blanking begins. The requester is held while the live scanline is inside the band. It is released once the scanline leaves the band, or once a one-millisecond cap runs out.

At release the block records the frame counter and the scanline. When the requester later signals that its writes are finished, the block compares the recorded frame number with the live one and raises a failure flag if a frame boundary was crossed. In interlaced timing, the blanking line is halved, rounding up, before the band is formed. If the band collapses to line zero or below, the request is released at once.

Top module: `vbl_evade_guard`

## Requirements
- R1: At grant, `win_hi` equals the effective blanking line minus 1, and `win_lo` equals the effective blanking line minus the budget in scanlines. Both are two's complement.
- R2: The budget in scanlines equals ceil(BUDGET_US × pix_khz / (1000 × htotal)). An exact quotient gets no round-up.
- R3: When `htotal` is zero, the budget is 1 scanline.
- R4: When `interlaced` is 1, the effective blanking line is ceil(vbl_start / 2). Otherwise it is vbl_start.
- R5: If `win_lo` ≤ 0 or `win_hi` ≤ 0, grant follows without waiting. `evade_timeout` is 0, and `start_frame` and `start_line` are cleared to 0.
- R6: While waiting, no grant is issued while `win_lo` ≤ scanline ≤ `win_hi`. A grant is issued in the cycle after the scanline is seen below `win_lo` or above `win_hi`.
- R7: After CYC_PER_MS cycles of waiting inside the band, grant is issued with `evade_timeout` = 1. A grant for any other reason leaves `evade_timeout` = 0.
- R8: On a waited grant, `start_frame` and `start_line` hold the `frame_cnt` and `scanline` values from the deciding cycle.
- R9: One cycle after `end_pulse`, `update_fail` is 1 only if `start_frame` is nonzero and differs from `frame_cnt`. Otherwise it is 0. The flag holds until the next `end_pulse`.
- R10: `busy` is 1 from the cycle after an accepted `start_req` until `grant`, and is 0 when `grant` is 1. A `start_req` while `busy` is 1 has no effect on the window or the timing.
- R11: After reset, `busy`, `grant`, `evade_timeout`, `update_fail`, `start_frame` and `start_line` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Pulse asking to begin an update |
| end_pulse | input | 1 | Pulse marking the end of an update |
| scanline | input | LINE_W | Live scanline |
| vbl_start | input | LINE_W | Line on which vertical blanking begins |
| htotal | input | LINE_W | Horizontal total in pixels |
| pix_khz | input | CLK_W | Pixel clock in kHz |
| interlaced | input | 1 | Interlaced timing |
| frame_cnt | input | FRAME_W | Running frame counter |
| busy | output | 1 | Request accepted and not yet granted |
| grant | output | 1 | One-cycle pulse: the update may start |
| evade_timeout | output | 1 | Last grant came from the time cap |
| win_lo | output | CLK_W+clog2(BUDGET_US+1)+1 | Lower band bound, signed |
| win_hi | output | CLK_W+clog2(BUDGET_US+1)+1 | Upper band bound, signed |
| start_frame | output | FRAME_W | Frame number recorded at grant |
| start_line | output | LINE_W | Scanline recorded at grant |
| update_fail | output | 1 | Last completed update crossed a frame |

## Verification
The end-of-update comparison and the start of the next request can fall in the same cycle. The bench provokes this by raising `end_pulse` and `start_req` together after the frame counter has moved on. The failure flag must then be judged against the frame number recorded for the previous update, not the new one. The new request must still be accepted, and at its grant it must record the new frame number, so that a following matching end pulse clears the flag. Separately, the deciding cycle in which the scanline leaves the band races against the last cycle of the time cap. Scanlines are chosen on both band edges and one line beyond each edge.

// File: rtl/vbl_guard_pkg.sv
// Package: shared state encoding for the update window guard.
// Assumes: nothing beyond the users importing it.
package vbl_guard_pkg;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_DIV  = 2'd1,
        GS_EVAL = 2'd2,
        GS_WAIT = 2'd3
    } guard_state_e;

endpackage

// File: rtl/vbl_line_budget.sv
// Module: converts a microsecond budget into scanlines with a ceiling divide.
// Computes ceil(BUDGET_US*khz / (1000*htotal)) with a restoring divider.
// The divider produces one quotient bit per cycle. A zero htotal yields 1.
// Assumes: go is only honoured while not busy; operands are sampled with go.
module vbl_line_budget #(
    parameter int LINE_W    = 13,
    parameter int CLK_W     = 20,
    parameter int BUDGET_US = 100,
    localparam int BUD_W    = $clog2(BUDGET_US + 1),
    localparam int NUM_W    = CLK_W + BUD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CLK_W-1:0]  khz,
    input  logic [LINE_W-1:0] htotal,
    output logic              busy,
    output logic              done,
    output logic [NUM_W-1:0]  lines
);
    localparam int DEN_W = LINE_W + 10;
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W:0]   rem_q;
    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   rem_nx;
    logic             take;
    logic [NUM_W-1:0] quo_nx;

    // One restoring step: shift in the next dividend bit and subtract if it fits.
    always_comb begin
        trial  = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
        take   = (trial >= {1'b0, den_q});
        rem_nx = take ? (trial - {1'b0, den_q}) : trial;
        quo_nx = {quo_q[NUM_W-2:0], take};
    end

    // Sequencing of the divide and the rounded result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
            lines <= '0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                if (htotal == '0) begin
                    lines <= NUM_W'(1);
                    done  <= 1'b1;
                end else begin
                    quo_q <= NUM_W'(khz) * NUM_W'(BUDGET_US);
                    den_q <= DEN_W'(htotal) * DEN_W'(1000);
                    rem_q <= '0;
                    cnt_q <= CNT_W'(NUM_W);
                    busy  <= 1'b1;
                end
            end else if (busy) begin
                rem_q <= rem_nx;
                quo_q <= quo_nx;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    lines <= quo_nx + NUM_W'(rem_nx != '0);
                end
            end
        end
    end

    // R2: the result pulse only appears once the divide has stopped.
    a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2: the remainder never reaches the divisor while dividing.
    a_r2_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rem_q < {1'b0, den_q}));

endmodule

// File: rtl/vbl_window_calc.sv
// Module: forms the guard band from the blanking line and the line budget.
// In interlaced timing the blanking line is halved, rounding up.
// Assumes: WIN_W is wider than LINE_W+1, so both bounds fit signed.
module vbl_window_calc #(
    parameter int LINE_W = 13,
    parameter int NUM_W  = 27,
    localparam int WIN_W = NUM_W + 1
) (
    input  logic                    interlaced,
    input  logic [LINE_W-1:0]       vbl_start,
    input  logic [NUM_W-1:0]        lines,
    output logic signed [WIN_W-1:0] lo,
    output logic signed [WIN_W-1:0] hi,
    output logic                    skip
);
    logic [LINE_W:0]          eff_line;
    logic signed [WIN_W-1:0]  eff_s;
    logic signed [WIN_W-1:0]  lines_s;

    // Band bounds and the collapse test.
    always_comb begin
        eff_line = interlaced ? (({1'b0, vbl_start} + 1'b1) >> 1) : {1'b0, vbl_start};
        eff_s    = $signed({{(WIN_W-LINE_W-1){1'b0}}, eff_line});
        lines_s  = $signed({1'b0, lines});
        lo       = eff_s - lines_s;
        hi       = eff_s - 1;
        skip     = (lo <= 0) || (hi <= 0);
    end

endmodule

// File: rtl/vbl_evade_ctrl.sv
// Module: request sequencing, band wait, time cap and capture at grant.
// A request starts the divide, then the band is latched and evaluated.
// The controller then waits for the scanline to leave the band or for the cap.
// Assumes: scanline is synchronous to clk; CYC_PER_MS is at least 2.
module vbl_evade_ctrl
    import vbl_guard_pkg::*;
#(
    parameter int LINE_W     = 13,
    parameter int FRAME_W    = 32,
    parameter int WIN_W      = 28,
    parameter int CYC_PER_MS = 250000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_req,
    input  logic [LINE_W-1:0]       scanline,
    input  logic [LINE_W-1:0]       vbl_start,
    input  logic                    interlaced,
    input  logic [FRAME_W-1:0]      frame_cnt,
    input  logic                    div_done,
    input  logic signed [WIN_W-1:0] lo_in,
    input  logic signed [WIN_W-1:0] hi_in,
    input  logic                    skip_in,
    output logic                    div_go,
    output logic [LINE_W-1:0]       vbl_q,
    output logic                    intl_q,
    output logic                    busy,
    output logic                    grant,
    output logic                    evade_timeout,
    output logic signed [WIN_W-1:0] win_lo,
    output logic signed [WIN_W-1:0] win_hi,
    output logic [FRAME_W-1:0]      start_frame,
    output logic [LINE_W-1:0]       start_line
);
    localparam int TMO_W = $clog2(CYC_PER_MS + 1);

    guard_state_e            st;
    logic                    skip_q;
    logic [TMO_W-1:0]        tmo_cnt;
    logic signed [WIN_W-1:0] line_s;
    logic                    outside;
    logic                    tmo_last;

    // Band test against the live scanline and the cap test.
    always_comb begin
        line_s   = $signed({{(WIN_W-LINE_W){1'b0}}, scanline});
        outside  = (line_s < win_lo) || (line_s > win_hi);
        tmo_last = (tmo_cnt == TMO_W'(CYC_PER_MS - 1));
        div_go   = (st == GS_IDLE) && start_req;
        busy     = (st != GS_IDLE);
    end

    // Request state machine with capture at grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= GS_IDLE;
            vbl_q         <= '0;
            intl_q        <= 1'b0;
            skip_q        <= 1'b0;
            tmo_cnt       <= '0;
            grant         <= 1'b0;
            evade_timeout <= 1'b0;
            win_lo        <= '0;
            win_hi        <= '0;
            start_frame   <= '0;
            start_line    <= '0;
        end else begin
            grant <= 1'b0;
            case (st)
                GS_IDLE: begin
                    if (start_req) begin
                        vbl_q  <= vbl_start;
                        intl_q <= interlaced;
                        st     <= GS_DIV;
                    end
                end
                GS_DIV: begin
                    if (div_done) begin
                        win_lo <= lo_in;
                        win_hi <= hi_in;
                        skip_q <= skip_in;
                        st     <= GS_EVAL;
                    end
                end
                GS_EVAL: begin
                    if (skip_q) begin
                        grant         <= 1'b1;
                        evade_timeout <= 1'b0;
                        start_frame   <= '0;
                        start_line    <= '0;
                        st            <= GS_IDLE;
                    end else begin
                        tmo_cnt <= '0;
                        st      <= GS_WAIT;
                    end
                end
                GS_WAIT: begin
                    if (outside || tmo_last) begin
                        grant         <= 1'b1;
                        evade_timeout <= !outside;
                        start_frame   <= frame_cnt;
                        start_line    <= scanline;
                        st            <= GS_IDLE;
                    end else begin
                        tmo_cnt <= tmo_cnt + 1'b1;
                    end
                end
                default: st <= GS_IDLE;
            endcase
        end
    end

    // R6: no release while the scanline sits inside the band and the cap is not reached.
    a_r6_stall_inside: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GS_WAIT && !outside && !tmo_last) |=> !grant);

    // R6: leaving the band releases on the next cycle.
    a_r6_release_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GS_WAIT && outside) |=> (grant && !evade_timeout));

    // R7: the wait counter never passes the cap.
    a_r7_cap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GS_WAIT) |-> (tmo_cnt < TMO_W'(CYC_PER_MS)));

    // R7: the timeout flag only rises together with a grant.
    a_r7_flag_with_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evade_timeout) |-> grant);

    // R5: a collapsed band releases at once with nothing recorded.
    a_r5_skip_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GS_EVAL && skip_q) |=> (grant && start_frame == '0 && !evade_timeout));

    // R10: grant closes the busy interval.
    a_r10_grant_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !busy);

endmodule

// File: rtl/vbl_frame_check.sv
// Module: judges at the end pulse whether the update crossed a frame.
// Assumes: start_frame is zero when no frame number was recorded.
module vbl_frame_check #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               end_pulse,
    input  logic [FRAME_W-1:0] frame_cnt,
    input  logic [FRAME_W-1:0] start_frame,
    output logic               update_fail
);
    // Verdict register, refreshed on every end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            update_fail <= 1'b0;
        end else if (end_pulse) begin
            update_fail <= (start_frame != '0) && (start_frame != frame_cnt);
        end
    end

    // R9: nothing recorded means no failure.
    a_r9_zero_capture_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (end_pulse && start_frame == '0) |=> !update_fail);

    // R9: a matching frame number means no failure.
    a_r9_match_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (end_pulse && start_frame == frame_cnt) |=> !update_fail);

    // R9: without an end pulse the verdict holds.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !end_pulse |=> $stable(update_fail));

endmodule

// File: rtl/vbl_evade_guard.sv
// Module: top of the update window guard.
// Wires the budget divider, the band calculator, the controller and the frame check.
// Assumes: all inputs are synchronous to clk.
module vbl_evade_guard #(
    parameter int LINE_W     = 13,
    parameter int CLK_W      = 20,
    parameter int FRAME_W    = 32,
    parameter int BUDGET_US  = 100,
    parameter int CYC_PER_MS = 250000,
    localparam int NUM_W     = CLK_W + $clog2(BUDGET_US + 1),
    localparam int WIN_W     = NUM_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_req,
    input  logic                    end_pulse,
    input  logic [LINE_W-1:0]       scanline,
    input  logic [LINE_W-1:0]       vbl_start,
    input  logic [LINE_W-1:0]       htotal,
    input  logic [CLK_W-1:0]        pix_khz,
    input  logic                    interlaced,
    input  logic [FRAME_W-1:0]      frame_cnt,
    output logic                    busy,
    output logic                    grant,
    output logic                    evade_timeout,
    output logic signed [WIN_W-1:0] win_lo,
    output logic signed [WIN_W-1:0] win_hi,
    output logic [FRAME_W-1:0]      start_frame,
    output logic [LINE_W-1:0]       start_line,
    output logic                    update_fail
);
    logic                    div_go;
    logic                    div_busy;
    logic                    div_done;
    logic [NUM_W-1:0]        lines;
    logic [LINE_W-1:0]       vbl_q;
    logic                    intl_q;
    logic signed [WIN_W-1:0] lo_c;
    logic signed [WIN_W-1:0] hi_c;
    logic                    skip_c;

    vbl_line_budget #(
        .LINE_W   (LINE_W),
        .CLK_W    (CLK_W),
        .BUDGET_US(BUDGET_US)
    ) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .khz   (pix_khz),
        .htotal(htotal),
        .busy  (div_busy),
        .done  (div_done),
        .lines (lines)
    );

    vbl_window_calc #(
        .LINE_W(LINE_W),
        .NUM_W (NUM_W)
    ) u_window (
        .interlaced(intl_q),
        .vbl_start (vbl_q),
        .lines     (lines),
        .lo        (lo_c),
        .hi        (hi_c),
        .skip      (skip_c)
    );

    vbl_evade_ctrl #(
        .LINE_W    (LINE_W),
        .FRAME_W   (FRAME_W),
        .WIN_W     (WIN_W),
        .CYC_PER_MS(CYC_PER_MS)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req),
        .scanline     (scanline),
        .vbl_start    (vbl_start),
        .interlaced   (interlaced),
        .frame_cnt    (frame_cnt),
        .div_done     (div_done),
        .lo_in        (lo_c),
        .hi_in        (hi_c),
        .skip_in      (skip_c),
        .div_go       (div_go),
        .vbl_q        (vbl_q),
        .intl_q       (intl_q),
        .busy         (busy),
        .grant        (grant),
        .evade_timeout(evade_timeout),
        .win_lo       (win_lo),
        .win_hi       (win_hi),
        .start_frame  (start_frame),
        .start_line   (start_line)
    );

    vbl_frame_check #(
        .FRAME_W(FRAME_W)
    ) u_fcheck (
        .clk        (clk),
        .rst_n      (rst_n),
        .end_pulse  (end_pulse),
        .frame_cnt  (frame_cnt),
        .start_frame(start_frame),
        .update_fail(update_fail)
    );

    // R10: the divider only runs while a request is outstanding.
    a_r10_div_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> busy);

endmodule

// File: tb/vbl_evade_guard_test.sv
module vbl_evade_guard_test;
    localparam int LW  = 13;
    localparam int CW  = 20;
    localparam int FW  = 32;
    localparam int CPM = 300;
    localparam int WW  = 28;

    typedef struct packed {
        int vbl; int htot; int khz; int intl; int scan; int lo; int hi; int kind;
    } vec_t;
    // kind: 0 released on leaving band, 1 time cap, 2 collapsed band
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1080, 2200, 148500, 0,  500, 1073, 1079, 0},  // R2 ceil 6.75 -> 7
        '{1080, 2200, 148500, 0, 1075, 1073, 1079, 1},
        '{1080, 2200, 148500, 0, 1079, 1073, 1079, 1},  // upper edge
        '{1080, 2200, 148500, 0, 1080, 1073, 1079, 0},  // one above
        '{1080, 2200, 148500, 0, 1072, 1073, 1079, 0},  // one below
        '{1081, 2200, 148500, 1,  538,  534,  540, 1},  // R4 541
        '{1081, 2200, 148500, 1,  541,  534,  540, 0},
        '{ 100,    0, 148500, 0,   99,   99,   99, 1},  // R3
        '{ 100,    0, 148500, 0,   98,   99,   99, 0},
        '{ 600, 1000, 100000, 0,  590,  590,  599, 1},  // R2 exact 10
        '{ 600, 1000, 100000, 0,  589,  590,  599, 0},
        '{   7, 2200, 148500, 0,    3,    0,    6, 2},  // R5 lo zero
        '{   5, 2200, 148500, 0,    3,   -2,    4, 2},  // R5 lo negative
        '{   1,    0, 148500, 0,    0,    0,    0, 2}   // R5 hi zero
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0, end_pulse = 1'b0, interlaced = 1'b0;
    logic [LW-1:0] scanline = '0, vbl_start = '0, htotal = '0;
    logic [CW-1:0] pix_khz = '0;
    logic [FW-1:0] frame_cnt = '0;
    logic busy, grant, evade_timeout, update_fail;
    logic signed [WW-1:0] win_lo, win_hi;
    logic [FW-1:0] start_frame;
    logic [LW-1:0] start_line;

    int total = 0;
    int bad = 0;
    int wd = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    vbl_evade_guard #(.LINE_W(LW), .CLK_W(CW), .FRAME_W(FW), .BUDGET_US(100),
                      .CYC_PER_MS(CPM)) uut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .end_pulse(end_pulse),
        .scanline(scanline), .vbl_start(vbl_start), .htotal(htotal),
        .pix_khz(pix_khz), .interlaced(interlaced), .frame_cnt(frame_cnt),
        .busy(busy), .grant(grant), .evade_timeout(evade_timeout),
        .win_lo(win_lo), .win_hi(win_hi), .start_frame(start_frame),
        .start_line(start_line), .update_fail(update_fail));

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // pulse a request and count negedges until grant (cap 2000)
    task automatic request(output int cyc);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        cyc = 1;
        while (!grant && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic end_update(input logic [FW-1:0] f, input bit exp);
        frame_cnt = f;
        end_pulse = 1'b1;
        @(negedge clk);
        end_pulse = 1'b0;
        check(update_fail == exp, "R9 frame verdict", update_fail, exp);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd == 100000 && !done_flag) begin
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
            $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
            $finish;
        end
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(!busy && !grant && !evade_timeout && !update_fail, "R11 flags", busy, 0);
        check(start_frame == 0 && start_line == 0, "R11 captures", start_frame, 0);

        for (int i = 0; i < NV; i++) begin
            vbl_start = LW'(VECS[i].vbl);
            htotal = LW'(VECS[i].htot);
            pix_khz = CW'(VECS[i].khz);
            interlaced = VECS[i].intl[0];
            scanline = LW'(VECS[i].scan);
            frame_cnt = FW'(10 + i);
            @(negedge clk);
            request(cyc);
            check(grant, "R6/R7 grant seen", grant, 1);
            check(win_lo == WW'(VECS[i].lo), "R1/R2/R3/R4 lower bound", win_lo, VECS[i].lo);
            check(win_hi == WW'(VECS[i].hi), "R1/R4 upper bound", win_hi, VECS[i].hi);
            check(!busy, "R10 busy low at grant", busy, 0);
            case (VECS[i].kind)
                0: begin
                    check(!evade_timeout && cyc < 60, "R6 prompt release", cyc, 31);
                    check(start_frame == FW'(10 + i), "R8 frame", start_frame, 10 + i);
                    check(start_line == LW'(VECS[i].scan), "R8 line", start_line, VECS[i].scan);
                end
                1: begin
                    check(evade_timeout, "R7 flag", evade_timeout, 1);
                    check(cyc >= CPM && cyc < CPM + 60, "R7 cap length", cyc, CPM + 30);
                    check(start_frame == FW'(10 + i), "R8 frame on cap", start_frame, 10 + i);
                end
                default: begin
                    check(!evade_timeout && cyc < 60, "R5 immediate", cyc, 30);
                    check(start_frame == 0 && start_line == 0, "R5 no capture", start_frame, 0);
                end
            endcase
            @(negedge clk);
        end

        // R6 dynamic: stay inside, then leave above the band
        vbl_start = 1080; htotal = 2200; pix_khz = 148500; interlaced = 0;
        scanline = 1075; frame_cnt = 40;
        start_req = 1'b1; @(negedge clk); start_req = 1'b0;
        begin
            bit seen = 0;
            for (int k = 0; k < 80; k++) begin
                @(negedge clk);
                if (grant) seen = 1;
                // R10: second request while busy must be ignored
                if (k == 50) begin vbl_start = 200; start_req = 1'b1; end
                else start_req = 1'b0;
            end
            check(!seen && busy, "R6 stall inside band", seen, 0);
        end
        scanline = 1085;
        cyc = 0;
        while (!grant && cyc < 10) begin @(negedge clk); cyc++; end
        check(grant && cyc <= 3, "R6 release after leaving", cyc, 2);
        check(!evade_timeout && start_line == 1085, "R8 line after move", start_line, 1085);
        check(win_hi == 1079, "R10 window unchanged by ignored request", win_hi, 1079);
        @(negedge clk);
        check(!busy && !grant, "R10 no second grant", busy, 0);

        // R9 end-of-update verdicts (captured frame 40)
        end_update(40, 0);
        end_update(41, 1);

        // same cycle: end pulse judged on old capture while a new start is accepted
        vbl_start = 1080; scanline = 500; frame_cnt = 43;
        start_req = 1'b1; end_pulse = 1'b1;
        @(negedge clk);
        start_req = 1'b0; end_pulse = 1'b0;
        check(update_fail == 1, "R9 verdict uses old capture", update_fail, 1);
        check(busy, "R10 start accepted alongside end", busy, 1);
        cyc = 0;
        while (!grant && cyc < 100) begin @(negedge clk); cyc++; end
        check(start_frame == 43, "R8 new capture", start_frame, 43);
        end_update(43, 0);

        // R9 zero capture never fails: collapsed band then a moved frame
        vbl_start = 5; frame_cnt = 50;
        @(negedge clk);
        request(cyc);
        check(start_frame == 0, "R5 cleared capture", start_frame, 0);
        end_update(77, 0);

        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule